// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block guards a small bank of configuration registers behind an index/data port pair on a plain I/O write/read bus. After reset it is in run mode, where the two ports ignore writes and read as FFh. The host opens configuration mode by writing the key byte 87h to the base port on two consecutive base-port writes. The base port address is picked by a strap input that is captured while reset is held.

In configuration mode, a write to the base port loads the index. A read of the base port returns the index. The data port at base+1 reads and writes the register that the index selects. Writing AAh to the base port closes configuration mode.

The bank holds two registers:
- A tri-state register. Its four low bits drive per-interface tri-state enables.
- An option register. It holds three legacy IRQ-selection disable bits, a lock bit and a read-only copy of the strap.

Each peripheral's IRQ enable output is its legacy select input gated by its disable bit. Once the lock bit is set, the data port ignores writes and reads as FFh until the next reset.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: After reset the block is in run mode (cfg_active 0), tri_en is 0, every disable bit is 0 and the lock bit is 0.
- R2: The strap input is captured on each clock edge while reset is low and then held. Strap 0 places the base port at 2Eh and strap 1 places it at 4Eh. Key writes to the other address have no effect.
- R3: Two writes of 87h to the base port, with no other base-port write between them, set cfg_active on the clock edge of the second write.
- R4: A single key write, or a key write followed by a base-port write of any other value, leaves run mode in force. The second case restarts the sequence. Writes to addresses other than the base port do not break the sequence.
- R5: Outside configuration mode, reads of the base port, of base+1 or of any other address return FFh. Writes to base+1 change no register.
- R6: In configuration mode, a base-port write of any value other than AAh loads the index. A base-port read returns the index. A data-port read at an index with no register behind it returns 00h.
- R7: The tri-state register is at index 20h and resets to 00h. Bits 3:0 drive tri_en[3:0]: bit 3 FIR, bit 2 UART, bit 1 printer, bit 0 floppy. Bits 7:4 read as 0.
- R8: The option register is at index 21h. Bit 0 disables UART A, bit 1 disables the printer and bit 2 disables the floppy. irq_en[i] equals legacy_sel[i] AND NOT disable bit i, using the same bit order.
- R9: Bit 4 of the option register is the lock bit. While it is 1, data-port writes are ignored and data-port reads return FFh. The index stays usable. The lock clears only on reset.
- R10: A write of AAh to the base port in configuration mode clears cfg_active on that clock edge and leaves the index unchanged.
- R11: Bit 6 of the option register reads back the captured strap, and writes do not change it. Bits 7, 5 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| strap_in | input | 1 | Base-port select strap |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, FFh when not addressed |
| legacy_sel | input | N_IRQ | Legacy IRQ select bits of UART A, printer and floppy |
| tri_en | output | N_TRI | Per-interface tri-state enables |
| irq_en | output | N_IRQ | Effective IRQ enables |
| cfg_active | output | 1 | High in configuration mode |

## Verification
The checker asserts these properties on every cycle:
- Configuration mode can only be entered on a key write to the current base port.
- An exit write always closes configuration mode.
- Run mode reads of the port pair return FFh, and the registers are frozen in run mode and while locked.
- irq_en never exceeds legacy_sel and never contradicts a set disable bit.
- The captured strap never moves outside reset.

Some behaviour only the bench scenarios can show: restarting an interrupted key sequence, the strap choosing between the two base addresses across separate resets, register read-back with reserved bits masked, unmapped indices reading 00h, and the FFh data reads after locking.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

  localparam int CFG_DW = 8;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ARMED = 2'd1,
    ST_CFG   = 2'd2
  } unlock_st_t;

  // option register field positions
  localparam int OPT_LOCK_BIT  = 4;
  localparam int OPT_STRAP_BIT = 6;

  function automatic logic [15:0] sel_base(input logic strap,
                                           input logic [15:0] lo_addr,
                                           input logic [15:0] hi_addr);
    return strap ? hi_addr : lo_addr;
  endfunction

  function automatic logic irq_gate(input logic sel, input logic dis);
    return sel & ~dis;
  endfunction

  function automatic logic is_key(input logic [7:0] d, input logic [7:0] k);
    return d == k;
  endfunction

endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
  import cfg_unlock_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  KEY_VAL  = 8'h87,
  parameter logic [7:0]  EXIT_VAL = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              cfg_active
);

  unlock_st_t st_q, st_d;
  logic       base_wr;

  assign base_wr = wr && (addr == base_addr);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (base_wr && is_key(wdata, KEY_VAL)) st_d = ST_ARMED;
      ST_ARMED: if (base_wr) st_d = is_key(wdata, KEY_VAL) ? ST_CFG : ST_RUN;
      ST_CFG:   if (base_wr && is_key(wdata, EXIT_VAL)) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign cfg_active = (st_q == ST_CFG);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_unlock_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          N_TRI    = 4,
  parameter int          N_IRQ    = 3,
  parameter logic [7:0]  EXIT_VAL = 8'hAA,
  parameter logic [7:0]  IDX_TRI  = 8'h20,
  parameter logic [7:0]  IDX_OPT  = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              cfg_active,
  input  logic              strap_q,
  output logic [7:0]        rdata,
  output logic [N_TRI-1:0]  tri_q,
  output logic [N_IRQ-1:0]  dis_q,
  output logic              lock_q
);

  localparam logic [7:0] FF_BYTE = 8'hFF;

  logic [ADDR_W-1:0] data_addr;
  logic [7:0]        index_q;
  logic              idx_wr, data_wr;
  logic [7:0]        tri_view, opt_view, sel_view;

  assign data_addr = base_addr + ADDR_W'(1);
  assign idx_wr    = wr && cfg_active && (addr == base_addr) && (wdata != EXIT_VAL);
  assign data_wr   = wr && cfg_active && (addr == data_addr) && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      tri_q   <= '0;
      dis_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (idx_wr) index_q <= wdata;
      if (data_wr && index_q == IDX_TRI) tri_q <= wdata[N_TRI-1:0];
      if (data_wr && index_q == IDX_OPT) begin
        dis_q  <= wdata[N_IRQ-1:0];
        lock_q <= wdata[OPT_LOCK_BIT];
      end
    end
  end

  always_comb begin
    tri_view = '0;
    tri_view[N_TRI-1:0] = tri_q;
    opt_view = '0;
    opt_view[N_IRQ-1:0] = dis_q;
    opt_view[OPT_LOCK_BIT]  = lock_q;
    opt_view[OPT_STRAP_BIT] = strap_q;
  end

  always_comb begin
    if (index_q == IDX_TRI)      sel_view = tri_view;
    else if (index_q == IDX_OPT) sel_view = opt_view;
    else                         sel_view = '0;
  end

  always_comb begin
    rdata = FF_BYTE;
    if (rd && cfg_active) begin
      if (addr == base_addr)                rdata = index_q;
      else if (addr == data_addr && !lock_q) rdata = sel_view;
    end
  end

endmodule

// File: rtl/cfg_irq_gate.sv
module cfg_irq_gate
  import cfg_unlock_pkg::*;
#(
  parameter int N_IRQ = 3
) (
  input  logic [N_IRQ-1:0] legacy_sel,
  input  logic [N_IRQ-1:0] dis_q,
  output logic [N_IRQ-1:0] irq_en
);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_lane
    assign irq_en[g] = irq_gate(legacy_sel[g], dis_q[g]);
  end

endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
  import cfg_unlock_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          N_TRI    = 4,
  parameter int          N_IRQ    = 3,
  parameter logic [15:0] BASE_LO  = 16'h002E,
  parameter logic [15:0] BASE_HI  = 16'h004E,
  parameter logic [7:0]  KEY_VAL  = 8'h87,
  parameter logic [7:0]  EXIT_VAL = 8'hAA,
  parameter logic [7:0]  IDX_TRI  = 8'h20,
  parameter logic [7:0]  IDX_OPT  = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_in,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [N_IRQ-1:0]  legacy_sel,
  output logic [N_TRI-1:0]  tri_en,
  output logic [N_IRQ-1:0]  irq_en,
  output logic              cfg_active
);

  logic              strap_q;
  logic [ADDR_W-1:0] base_addr;
  logic [N_IRQ-1:0]  dis_q;
  logic              lock_q;

  // strap sampled while reset is held, then frozen
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  assign base_addr = ADDR_W'(sel_base(strap_q, BASE_LO, BASE_HI));

  cfg_key_seq #(
    .ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL), .EXIT_VAL(EXIT_VAL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(io_wr), .addr(io_addr), .wdata(io_wdata),
    .base_addr(base_addr), .cfg_active(cfg_active)
  );

  cfg_reg_bank #(
    .ADDR_W(ADDR_W), .N_TRI(N_TRI), .N_IRQ(N_IRQ), .EXIT_VAL(EXIT_VAL),
    .IDX_TRI(IDX_TRI), .IDX_OPT(IDX_OPT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(io_wr), .rd(io_rd), .addr(io_addr),
    .wdata(io_wdata), .base_addr(base_addr), .cfg_active(cfg_active),
    .strap_q(strap_q), .rdata(io_rdata), .tri_q(tri_en), .dis_q(dis_q),
    .lock_q(lock_q)
  );

  cfg_irq_gate #(.N_IRQ(N_IRQ)) u_gate (
    .legacy_sel(legacy_sel), .dis_q(dis_q), .irq_en(irq_en)
  );

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk #(
  parameter int          ADDR_W   = 8,
  parameter int          N_TRI    = 4,
  parameter int          N_IRQ    = 3,
  parameter logic [7:0]  KEY_VAL  = 8'h87,
  parameter logic [7:0]  EXIT_VAL = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [ADDR_W-1:0] base_addr,
  input logic              cfg_active,
  input logic [N_TRI-1:0]  tri_en,
  input logic [N_IRQ-1:0]  irq_en,
  input logic [N_IRQ-1:0]  legacy_sel,
  input logic [N_IRQ-1:0]  dis_q,
  input logic              lock_q,
  input logic              strap_q
);

  logic [ADDR_W-1:0] data_addr;
  assign data_addr = base_addr + ADDR_W'(1);

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (!cfg_active && tri_en == '0 && dis_q == '0 && !lock_q)); // R1

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(strap_q)); // R2

  AST_KEY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_active) |-> $past(io_wr && io_addr == base_addr && io_wdata == KEY_VAL)); // R3

  AST_RUN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && io_rd && (io_addr == base_addr || io_addr == data_addr))
      |-> io_rdata == 8'hFF); // R5

  AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |=> ($stable(tri_en) && $stable(dis_q))); // R5

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_en & dis_q) == '0) && ((irq_en & ~legacy_sel) == '0)); // R8

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(tri_en) && $stable(dis_q))); // R9

  AST_EXIT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && io_wr && io_addr == base_addr && io_wdata == EXIT_VAL)
      |=> !cfg_active); // R10

endmodule

bind cfg_unlock_ctrl cfg_unlock_chk #(
  .ADDR_W(ADDR_W), .N_TRI(N_TRI), .N_IRQ(N_IRQ),
  .KEY_VAL(KEY_VAL), .EXIT_VAL(EXIT_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .base_addr(base_addr),
  .cfg_active(cfg_active), .tri_en(tri_en), .irq_en(irq_en),
  .legacy_sel(legacy_sel), .dis_q(dis_q), .lock_q(lock_q), .strap_q(strap_q)
);

// File: tb/sim_cfg_unlock_ctrl.sv
module sim_cfg_unlock_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_in = 1'b0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic [2:0] legacy_sel = 3'b000;
  logic [7:0] io_rdata;
  logic [3:0] tri_en;
  logic [2:0] irq_en;
  logic       cfg_active;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_unlock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .legacy_sel(legacy_sel), .tri_en(tri_en), .irq_en(irq_en),
    .cfg_active(cfg_active)
  );

  // behavioural reference: mode 0 run, 1 one key seen, 2 configuration
  int         m_mode, m_index, m_base;
  logic [3:0] m_tri;
  logic [2:0] m_dis;
  bit         m_lock, m_strap;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_index = 0; m_tri = 4'h0; m_dis = 3'b000; m_lock = 0;
      m_strap = strap_in;
    end else if (io_wr) begin
      m_base = m_strap ? 'h4E : 'h2E;
      if (int'(io_addr) == m_base) begin
        if (m_mode == 0) begin
          if (io_wdata == 8'h87) m_mode = 1;
        end else if (m_mode == 1) begin
          m_mode = (io_wdata == 8'h87) ? 2 : 0;
        end else begin
          if (io_wdata == 8'hAA) m_mode = 0;
          else m_index = int'(io_wdata);
        end
      end else if (int'(io_addr) == m_base + 1 && m_mode == 2 && !m_lock) begin
        if (m_index == 'h20) m_tri = io_wdata[3:0];
        else if (m_index == 'h21) begin
          m_dis = io_wdata[2:0];
          m_lock = io_wdata[4];
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (cfg_active !== (m_mode == 2)) begin
        miscompares++;
        $display("FAIL R3: cfg_active got %0b expected %0b", cfg_active, m_mode == 2);
      end
      if (tri_en !== m_tri) begin
        miscompares++;
        $display("FAIL R7: tri_en got %0h expected %0h", tri_en, m_tri);
      end
      if (irq_en !== (legacy_sel & ~m_dis)) begin
        miscompares++;
        $display("FAIL R8: irq_en got %0b expected %0b", irq_en, legacy_sel & ~m_dis);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    io_wr = 0; io_rd = 0; rst_n = 0; strap_in = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_rd = 0; io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd_port(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_wr = 0; io_rd = 1; io_addr = a;
    #1 chk(req, io_rdata, exp);
    io_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R1 reset state
    chk("R1", {7'b0, cfg_active}, 8'h00);
    chk("R1", {4'b0, tri_en}, 8'h00);
    // R5 run mode isolation
    rd_port(8'h2E, 8'hFF, "R5");
    rd_port(8'h2F, 8'hFF, "R5");
    rd_port(8'h60, 8'hFF, "R5");
    wr_port(8'h2F, 8'hFF);
    chk("R5", {4'b0, tri_en}, 8'h00);
    // R4 broken and single key
    wr_port(8'h2E, 8'h87);
    chk("R4", {7'b0, cfg_active}, 8'h00);
    wr_port(8'h2E, 8'h12);
    wr_port(8'h2E, 8'h87);
    chk("R4", {7'b0, cfg_active}, 8'h00);
    // R3 second consecutive key opens
    wr_port(8'h2E, 8'h87);
    chk("R3", {7'b0, cfg_active}, 8'h01);
    // R6 / R7 tri-state register
    wr_port(8'h2E, 8'h20);
    rd_port(8'h2E, 8'h20, "R6");
    wr_port(8'h2F, 8'h5A);
    chk("R7", {4'b0, tri_en}, 8'h0A);
    rd_port(8'h2F, 8'h0A, "R7");
    // R8 / R11 option register
    legacy_sel = 3'b111;
    wr_port(8'h2E, 8'h21);
    wr_port(8'h2F, 8'h45);
    chk("R8", {5'b0, irq_en}, 8'h02);
    rd_port(8'h2F, 8'h05, "R11");
    legacy_sel = 3'b011;
    wr_port(8'h2F, 8'h00);
    chk("R8", {5'b0, irq_en}, 8'h03);
    // R6 unmapped index
    wr_port(8'h2E, 8'h30);
    rd_port(8'h2F, 8'h00, "R6");
    // R10 exit, index kept
    wr_port(8'h2E, 8'h20);
    wr_port(8'h2E, 8'hAA);
    chk("R10", {7'b0, cfg_active}, 8'h00);
    wr_port(8'h2F, 8'h03);
    chk("R5", {4'b0, tri_en}, 8'h0A);
    wr_port(8'h2E, 8'h87);
    wr_port(8'h2E, 8'h87);
    rd_port(8'h2E, 8'h20, "R10");
    // R2 strap 1 moves the base port
    do_reset(1'b1);
    chk("R1", {4'b0, tri_en}, 8'h00);
    wr_port(8'h2E, 8'h87);
    wr_port(8'h2E, 8'h87);
    chk("R2", {7'b0, cfg_active}, 8'h00);
    wr_port(8'h4E, 8'h87);
    wr_port(8'h60, 8'h55);
    wr_port(8'h4E, 8'h87);
    chk("R2", {7'b0, cfg_active}, 8'h01);
    wr_port(8'h4E, 8'h21);
    rd_port(8'h4F, 8'h40, "R11");
    // R9 lock
    wr_port(8'h4F, 8'h10);
    rd_port(8'h4F, 8'hFF, "R9");
    wr_port(8'h4E, 8'h20);
    wr_port(8'h4F, 8'h0F);
    chk("R9", {4'b0, tri_en}, 8'h00);
    rd_port(8'h4E, 8'h20, "R9");
    wr_port(8'h4E, 8'hAA);
    chk("R10", {7'b0, cfg_active}, 8'h00);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule